// File: doc/BRIEF.md
# Eight-Channel Output Compare Timer

The block keeps one 16-bit up-counter and eight compare channels. A prescaler advances the counter once every 1, 2, 4 ... 128 clocks. On a prescaled tick, each channel that is set up for output compare checks its 16-bit compare value against the counter. When they are equal, the channel raises its status flag and applies a two-bit action to its own pin. The flag can also drive an interrupt line for that channel.

Channel 7 has two extra roles. When it matches, it drives a masked group of pins to programmed levels, and this overrides the action of any other channel on those pins. It can also restart the counter, so that its compare value sets the period of a set of PWM outputs. Software can apply a channel's action without waiting for a match (a forced compare). It can also make a pin toggle each time the counter wraps.

Flags are cleared by writing 1. An optional fast-clear mode also clears a channel's flag whenever that channel's compare value is written. Registers are reached through a simple write strobe and an asynchronous read port.

Top module: `octa_cmp_unit`

## Requirements
- R1: The counter (read at address 8) advances by one on each prescaled tick. A tick comes once every 2^P clocks, where P is CTRL[6:4] at address 0. The counter holds while CTRL[0] (enable) is 0.
- R2: When a tick takes the counter from 0xFFFF to 0x0000, STATUS bit 8 (address 4) sets. `irq_ovf` is that bit ANDed with CTRL[7].
- R3: A selected channel (SEL[i] at address 1 equal to 1) whose compare register (address 16+i) equals the counter on a tick sets STATUS[i]. This happens once per counter value. `irq_ch[i]` is STATUS[i] ANDed with IEN[i] at address 3.
- R4: On a match, pin i takes the action in ACT[2i+1:2i] at address 2: 00 no change, 01 toggle, 10 low, 11 high. The pin changes on the clock edge that ends the tick cycle. With no event, a pin keeps its level.
- R5: When channel 7 matches, every pin whose bit is set in MASTER[7:0] (address 6) takes the level in MASTER[15:8]. This wins over any other action on that pin in the same cycle.
- R6: With CTRL[2] set, a channel 7 match makes the counter restart at 0 on the next tick instead of advancing.
- R7: Writing 1 to bit i at address 5 applies channel i's action at once. For bit 7 this includes the masked group. The write never sets a flag.
- R8: With TOV[i] set (address 7) on a selected channel, pin i toggles on a counter wrap.
- R9: Writing 1 to a STATUS bit clears it, and writing 0 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R10: With CTRL[1] set, writing channel i's compare register clears STATUS[i].
- R11: An unselected channel never sets its flag and never acts on its pin, whether by match, forced compare or overflow toggle.
- R12: After reset, all registers, flags, pins and the counter are zero, the prescale is 1 and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pins | output | 8 | Compare output pins |
| irq_ch | output | 8 | Per-channel interrupt requests |
| irq_ovf | output | 1 | Counter-wrap interrupt request |

## Verification
The assertions assume that the prescale field only changes while a tick cannot land on the cycle right after a change. They also assume that writes arrive as single-cycle strobes with stable address and data. The bench changes the prescale only between whole counter steps and drives every write for exactly one clock. The tests that depend on a match set each compare value well ahead of the running counter, so every match happens after its configuration is complete. The counter wrap is reached by letting the counter run at divide-by-1, not by loading it.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int PS_W  = 3;
  localparam int PRE_W = (1 << PS_W) - 1;
  localparam int AW    = 5;

  localparam logic [AW-1:0] A_CTRL  = 5'd0;
  localparam logic [AW-1:0] A_SEL   = 5'd1;
  localparam logic [AW-1:0] A_ACT   = 5'd2;
  localparam logic [AW-1:0] A_IEN   = 5'd3;
  localparam logic [AW-1:0] A_STAT  = 5'd4;
  localparam logic [AW-1:0] A_FORCE = 5'd5;
  localparam logic [AW-1:0] A_MST   = 5'd6;
  localparam logic [AW-1:0] A_TOV   = 5'd7;
  localparam logic [AW-1:0] A_CNT   = 5'd8;
  localparam logic [AW-1:0] A_CMP0  = 5'd16;

  localparam int C_EN   = 0;
  localparam int C_FCLR = 1;
  localparam int C_RST7 = 2;
  localparam int C_PS   = 4;
  localparam int C_OVIE = 7;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  // low bits of the prescaler that must all be set for a tick
  function automatic logic [PRE_W-1:0] tick_mask(input logic [PS_W-1:0] ps);
    return PRE_W'((1 << ps) - 1);
  endfunction

  function automatic logic act_level(input act_e a, input logic cur);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_timebase.sv
module ocu_timebase #(
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [ocu_pkg::PS_W-1:0]  ps_sel,
  input  logic                      clr_cnt,
  output logic                      tick,
  output logic                      ovf_evt,
  output logic [CW-1:0]             cnt
);
  import ocu_pkg::*;

  logic [PRE_W-1:0] pre_q;

  assign tick    = enable && ((pre_q & tick_mask(ps_sel)) == tick_mask(ps_sel));
  assign ovf_evt = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else if (enable) begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt <= clr_cnt ? '0 : cnt + 1'b1;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps_sel != '0) |=> (!tick || ps_sel == '0))
    else $error("tick repeated with prescale above one");

  assert_ovf_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0))
    else $error("overflow event without counter wrap");

  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt))
    else $error("counter moved while stopped");
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          oc_sel,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          flag_w1c,
  input  logic          fast_clr,
  output logic [CW-1:0] cmp_q,
  output logic          match,
  output logic          flag
);
  assign match = tick && oc_sel && (cnt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      flag <= match | (flag & ~(flag_w1c | (cmp_we & fast_clr)));
    end
  end

  assert_flag_from_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match))
    else $error("flag rose without a match");
endmodule

// File: rtl/ocu_pin_ctrl.sv
module ocu_pin_ctrl #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ev,
  input  logic [2*NCH-1:0] act,
  input  logic [NCH-1:0]   m_mask,
  input  logic [NCH-1:0]   m_data,
  input  logic [NCH-1:0]   tov,
  input  logic [NCH-1:0]   oc_sel,
  input  logic             ovf_evt,
  output logic [NCH-1:0]   pins
);
  import ocu_pkg::*;
  localparam int MST = NCH - 1;

  logic [NCH-1:0] nxt;

  // priority, lowest first: wrap toggle, own action, master group
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      nxt[i] = pins[i];
      if (ovf_evt && tov[i] && oc_sel[i]) nxt[i] = ~pins[i];
      if (ev[i] && act_e'(act[2*i +: 2]) != ACT_NONE)
        nxt[i] = act_level(act_e'(act[2*i +: 2]), pins[i]);
      if (ev[MST] && m_mask[i]) nxt[i] = m_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins <= '0;
    else        pins <= nxt;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mst
    assert_master_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[MST] && m_mask[g]) |=> (pins[g] == $past(m_data[g])))
      else $error("master level not applied");
  end

  assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0 && !ovf_evt) |=> $stable(pins))
    else $error("pin moved without an event");
endmodule

// File: rtl/octa_cmp_unit.sv
module octa_cmp_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ocu_pkg::AW-1:0]  wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic [ocu_pkg::AW-1:0]  rd_addr,
  output logic [CW-1:0]           rd_data,
  output logic [NCH-1:0]          pins,
  output logic [NCH-1:0]          irq_ch,
  output logic                    irq_ovf
);
  import ocu_pkg::*;
  localparam int MST = NCH - 1;

  logic en_q, fclr_q, rst7_q, ovie_q, ovf_flag;
  logic [PS_W-1:0]  ps_q;
  logic [NCH-1:0]   sel_q, ie_q, mmask_q, mdata_q, tov_q;
  logic [2*NCH-1:0] act_q;

  logic             tick, ovf_evt;
  logic [CW-1:0]    cnt;
  logic [NCH-1:0]   match, flags, cmp_we, flag_w1c, force_v, ev;
  logic [CW-1:0]    cmp_q [NCH];
  logic             stat_wr, ovf_clr;

  assign stat_wr  = wr_en && (wr_addr == A_STAT);
  assign flag_w1c = stat_wr ? wr_data[NCH-1:0] : '0;
  assign ovf_clr  = stat_wr && wr_data[NCH];
  assign force_v  = (wr_en && wr_addr == A_FORCE) ? wr_data[NCH-1:0] : '0;
  assign ev       = match | (force_v & sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; fclr_q <= 1'b0; rst7_q <= 1'b0; ovie_q <= 1'b0;
      ps_q <= '0; sel_q <= '0; ie_q <= '0; mmask_q <= '0; mdata_q <= '0;
      tov_q <= '0; act_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en_q   <= wr_data[C_EN];
          fclr_q <= wr_data[C_FCLR];
          rst7_q <= wr_data[C_RST7];
          ps_q   <= wr_data[C_PS +: PS_W];
          ovie_q <= wr_data[C_OVIE];
        end
        A_SEL:  sel_q <= wr_data[NCH-1:0];
        A_ACT:  act_q <= wr_data[2*NCH-1:0];
        A_IEN:  ie_q  <= wr_data[NCH-1:0];
        A_MST: begin
          mmask_q <= wr_data[NCH-1:0];
          mdata_q <= wr_data[NCH +: NCH];
        end
        A_TOV:  tov_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);
  end

  ocu_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .ps_sel(ps_q),
    .clr_cnt(match[MST] && rst7_q), .tick(tick), .ovf_evt(ovf_evt), .cnt(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmp_we[i] = wr_en && (wr_addr == AW'(A_CMP0 + i));
    ocu_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .oc_sel(sel_q[i]),
      .cmp_we(cmp_we[i]), .cmp_wdata(wr_data), .flag_w1c(flag_w1c[i]),
      .fast_clr(fclr_q), .cmp_q(cmp_q[i]), .match(match[i]), .flag(flags[i])
    );
  end

  ocu_pin_ctrl #(.NCH(NCH)) u_pins (
    .clk(clk), .rst_n(rst_n), .ev(ev), .act(act_q), .m_mask(mmask_q),
    .m_data(mdata_q), .tov(tov_q), .oc_sel(sel_q), .ovf_evt(ovf_evt), .pins(pins)
  );

  assign irq_ch  = flags & ie_q;
  assign irq_ovf = ovf_flag & ovie_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = CW'({ovie_q, ps_q, 1'b0, rst7_q, fclr_q, en_q});
      A_SEL:  rd_data = CW'(sel_q);
      A_ACT:  rd_data = CW'(act_q);
      A_IEN:  rd_data = CW'(ie_q);
      A_STAT: rd_data = CW'({ovf_flag, flags});
      A_MST:  rd_data = CW'({mdata_q, mmask_q});
      A_TOV:  rd_data = CW'(tov_q);
      A_CNT:  rd_data = cnt;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (rd_addr == AW'(A_CMP0 + i)) rd_data = cmp_q[i];
      end
    endcase
  end

  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match[MST] && rst7_q) |=> (cnt == '0))
    else $error("counter did not restart on master match");

  assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_v != '0 && match == '0) |=> ((flags & ~$past(flags)) == '0))
    else $error("forced compare set a flag");
endmodule

// File: tb/octa_cmp_unit_test.sv
module octa_cmp_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  wire [15:0] rd_data;
  wire [7:0] pins, irq_ch;
  wire irq_ovf;

  int checks = 0, errors = 0;
  string cur_req = "R12";
  bit done = 0;

  octa_cmp_unit uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pins(pins),
    .irq_ch(irq_ch), .irq_ovf(irq_ovf));

  always #10 clk = ~clk;

  // behavioural reference state
  int m_cnt = 0, m_pre = 0, m_ps = 0;
  bit m_en = 0, m_fclr = 0, m_rst7 = 0, m_ovie = 0, m_ovf = 0;
  bit [7:0] m_sel = 0, m_ie = 0, m_mask = 0, m_data = 0, m_tov = 0, m_flag = 0, m_pin = 0;
  bit [15:0] m_act = 0;
  int m_cmp [8];
  bit tk, ov;
  bit [7:0] mt, evv, np, clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ps = 0; m_en = 0; m_fclr = 0; m_rst7 = 0; m_ovie = 0;
      m_ovf = 0; m_sel = 0; m_ie = 0; m_mask = 0; m_data = 0; m_tov = 0;
      m_flag = 0; m_pin = 0; m_act = 0;
      foreach (m_cmp[k]) m_cmp[k] = 0;
    end else begin
      tk = m_en && (((m_pre + 1) % (1 << m_ps)) == 0);
      ov = tk && (m_cnt == 65535);
      mt = 0;
      for (int i = 0; i < 8; i++) if (tk && m_sel[i] && m_cmp[i] == m_cnt) mt[i] = 1;
      evv = mt;
      if (wr_en && wr_addr == 5) evv = evv | (wr_data[7:0] & m_sel);
      np = m_pin;
      for (int i = 0; i < 8; i++) begin
        if (ov && m_tov[i] && m_sel[i]) np[i] = !m_pin[i];
        if (evv[i]) case (m_act[2*i +: 2])
          2'b01: np[i] = !m_pin[i];
          2'b10: np[i] = 0;
          2'b11: np[i] = 1;
          default: ;
        endcase
        if (evv[7] && m_mask[i]) np[i] = m_data[i];
      end
      m_pin = np;
      clr = (wr_en && wr_addr == 4) ? wr_data[7:0] : 8'h00;
      for (int i = 0; i < 8; i++) if (wr_en && wr_addr == 16 + i && m_fclr) clr[i] = 1;
      m_flag = (m_flag & ~clr) | mt;
      m_ovf = ov | (m_ovf && !(wr_en && wr_addr == 4 && wr_data[8]));
      if (m_en) begin
        m_pre = (m_pre + 1) % 128;
        if (tk) m_cnt = (mt[7] && m_rst7) ? 0 : (m_cnt + 1) % 65536;
      end
      if (wr_en) begin
        case (wr_addr)
          0: begin m_en = wr_data[0]; m_fclr = wr_data[1]; m_rst7 = wr_data[2];
                   m_ps = int'(wr_data[6:4]); m_ovie = wr_data[7]; end
          1: m_sel = wr_data[7:0];
          2: m_act = wr_data;
          3: m_ie = wr_data[7:0];
          6: begin m_mask = wr_data[7:0]; m_data = wr_data[15:8]; end
          7: m_tov = wr_data[7:0];
          default: if (wr_addr >= 16) m_cmp[wr_addr - 16] = int'(wr_data);
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, " pins"}, int'(pins), int'(m_pin));
    chk({cur_req, " irq_ch"}, int'(irq_ch), int'(m_flag & m_ie));
    chk({cur_req, " irq_ovf"}, int'(irq_ovf), int'(m_ovf && m_ovie));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 5'(a); #1;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    int v, a, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    rd(8, v); chk("R12 count", v, 0);
    rd(4, v); chk("R12 status", v, 0);
    rd(0, v); chk("R12 ctrl", v, 0);
    chk("R12 pins", int'(pins), 0);
    idle(5);
    rd(8, v); chk("R1 stopped counter holds", v, 0);

    cur_req = "R1";
    wr(0, 16'h0021);
    idle(3);
    rd(8, a); idle(7); rd(8, v); chk("R1 divide by 4", v - a, 2);
    wr(0, 16'h0001);
    rd(8, a); idle(9); rd(8, v); chk("R1 divide by 1", v - a, 10);

    cur_req = "R4";
    wr(1, 16'h00FF); wr(2, 16'h002D); wr(3, 16'h00FF);
    c = m_cnt + 40;
    wr(16, c); wr(17, c + 1); wr(18, c + 2);
    idle(60);
    rd(4, v);
    chk("R3 flags set", v & 255, 7);
    chk("R3 irq", int'(irq_ch), 7);
    chk("R4 toggle/high/low", int'(pins[2:0]), 3);

    cur_req = "R9";
    wr(4, 16'h0001); rd(4, v); chk("R9 w1c clears", v & 255, 6);
    wr(4, 16'h0000); rd(4, v); chk("R9 zero keeps", v & 255, 6);

    cur_req = "R10";
    wr(0, 16'h0003);
    wr(17, m_cnt + 1000);
    rd(4, v); chk("R10 fast clear", v & 255, 4);
    wr(0, 16'h0001);

    cur_req = "R5";
    wr(6, 16'h0103);
    c = m_cnt + 30;
    wr(16, c); wr(23, c);
    idle(50);
    chk("R5 master beats toggle", int'(pins[0]), 1);
    chk("R5 master drives low", int'(pins[1]), 0);
    rd(4, v); chk("R3 master flag", (v >> 7) & 1, 1);

    cur_req = "R6";
    c = m_cnt + 20;
    wr(23, c); wr(0, 16'h0005);
    idle(100);
    rd(8, v); chk("R6 counter bounded by period", int'(v <= c), 1);

    cur_req = "R7";
    wr(0, 16'h0001); wr(2, 16'h003D); wr(4, 16'h01FF);
    wr(5, 16'h0004);
    rd(4, v);
    chk("R7 forced high", int'(pins[2]), 1);
    chk("R7 no flag", (v >> 2) & 1, 0);

    cur_req = "R11";
    wr(1, 16'h00F7); wr(2, 16'h007D);
    wr(19, m_cnt + 20);
    idle(40);
    rd(4, v); chk("R11 no flag", (v >> 3) & 1, 0);
    chk("R11 pin held", int'(pins[3]), 0);
    wr(5, 16'h0008); idle(1);
    chk("R11 force ignored", int'(pins[3]), 0);

    cur_req = "R8";
    wr(7, 16'h0018); wr(0, 16'h0081);
    while (m_cnt < 65530) @(negedge clk);
    idle(10);
    rd(4, v);
    chk("R2 wrap flag", (v >> 8) & 1, 1);
    chk("R2 wrap irq", int'(irq_ovf), 1);
    chk("R8 selected pin toggled", int'(pins[4]), 1);
    chk("R8 unselected pin held", int'(pins[3]), 0);
    rd(8, v); chk("R2 counter wrapped", int'(v < 20), 1);
    cur_req = "R9";
    wr(4, 16'h0100); idle(1);
    chk("R9 wrap flag cleared", int'(irq_ovf), 0);
    finish_up();
  end
endmodule